// File: doc/BRIEF.md
# I2C Register-Write Slave

This block is an I2C target that lets an external bus master load a small bank of 8-bit registers. SCL and SDA come in from open-drain pads and are retimed into the system clock domain. The block finds START, repeated START and STOP conditions there, and checks the address byte against a fixed 7-bit device address with the write direction. The first byte after a matched address loads an internal 8-bit register pointer. Every later byte in the same transfer is stored at the pointed location, and the pointer then steps by one.

The block acknowledges a byte by asserting a pull-low enable on SDA for the ninth clock of that byte. Each stored byte also appears on a local write port: an address, the data and a one-cycle strobe. On-chip logic can read the bank at any time through a combinational read port. Read transfers, clock stretching, 10-bit addressing and general call are not handled.

Top module: `i2c_regbank_slave`

## Requirements
- R1: While reset is high, and after it is released, the SDA pull-low enable is 0, the write strobe is 0 and every bank entry reads back 0x00.
- R2: A START condition is SDA falling while SCL is high. A STOP condition is SDA rising while SCL is high. A STOP returns the block to idle at any point, and a byte cut short by a STOP is not written.
- R3: The address byte is shifted in MSB first on rising SCL. Bits 7..1 hold the device address (default 0x42), and bit 0 is the direction, where 0 means write. When the address matches with direction 0, the block holds SDA low through the high phase of the ninth clock.
- R4: When the address differs, or the direction bit is 1, the block does not acknowledge and ignores every further byte until the next START or STOP. No register is written.
- R5: The first byte after a matched address loads the register pointer. It is acknowledged and causes no write.
- R6: Each further byte is acknowledged and stored at the pointer. A one-cycle write strobe carries that address and data, and the pointer then increments by one.
- R7: The register pointer is 8 bits wide and wraps from 0xFF to 0x00 during a burst.
- R8: A byte whose pointer is at or above the bank depth (default 16) is acknowledged but discarded. No strobe is raised and the bank is unchanged.
- R9: A repeated START in the middle of a transfer sends the block straight back to address matching, and the new transfer proceeds normally.
- R10: The pull-low enable is raised only for acknowledge clocks. It is released on the falling SCL edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL pad level (asynchronous) |
| sda_i | input | 1 | SDA pad level (asynchronous) |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain SDA driver |
| wr_stb_o | output | 1 | One-cycle strobe for a stored byte |
| wr_addr_o | output | 8 | Register address of the stored byte |
| wr_data_o | output | 8 | Data of the stored byte |
| rd_addr_i | input | 8 | Local read address |
| rd_data_o | output | 8 | Bank contents at rd_addr_i (0 when out of range) |

## Verification
On every cycle, the assertions check the following. A STOP forces idle and a START forces address matching. The pull-low enable appears only in acknowledge phases and never while the bus is being ignored. Every write request advances the pointer by exactly one, with wrap. Strobes last one cycle and never carry an out-of-range address. Only the bench scenarios show the rest: that the bit order and address comparison are right, that acknowledges land in the ninth clock's high phase, that the pointer byte writes nothing, that bursts fill consecutive registers, and that aborted or ignored transfers leave the bank unchanged.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int DEVA_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } link_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic              req;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [DEVA_W-1:0] dev);
        return (b[BYTE_W-1:1] == dev) && !b[0];
    endfunction

    function automatic logic is_ack_state(input link_state_t s);
        return (s == ST_ADDR_ACK) || (s == ST_PTR_ACK) || (s == ST_DATA_ACK);
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
`timescale 1ns/1ps
module i2cs_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= 1'b1;
                    sda_chain <= 1'b1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[STAGES-2:0], scl_i};
                    sda_chain <= {sda_chain[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_now = scl_chain[STAGES-1];
    assign sda_now = sda_chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    always_comb begin
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
        ev.sda      = sda_now;
    end

endmodule

// File: rtl/i2cs_link.sv
`timescale 1ns/1ps
module i2cs_link
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output logic    sda_pull,
    output wr_req_t wr
);

    localparam logic [3:0] LAST_BIT = 4'd8;

    link_state_t        state;
    logic [3:0]         bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            sda_pull <= 1'b0;
            wr       <= '0;
        end else begin
            wr.req <= 1'b0;
            if (ev.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
            end else if (ev.start) begin
                state    <= ST_ADDR;
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_DATA: begin
                        if (ev.scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall && bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg, DEV_ADDR)) begin
                                    sda_pull <= 1'b1;
                                    state    <= ST_ADDR_ACK;
                                end else begin
                                    state    <= ST_IGNORE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr      <= shreg;
                                sda_pull <= 1'b1;
                                state    <= ST_PTR_ACK;
                            end else begin
                                wr.req   <= 1'b1;
                                wr.addr  <= ptr;
                                wr.data  <= shreg;
                                ptr      <= ptr + 8'd1;
                                sda_pull <= 1'b1;
                                state    <= ST_DATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_PTR;
                        end
                    end
                    ST_PTR_ACK, ST_DATA_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_DATA;
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> state == ST_IDLE); // R2

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !ev.stop) |=> state == ST_ADDR); // R9

    AST_PULL_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> is_ack_state(state)); // R10

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        state == ST_IGNORE |-> !sda_pull); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr.req |-> ptr == wr.addr + 8'd1); // R7

endmodule

// File: rtl/i2cs_regfile.sv
`timescale 1ns/1ps
module i2cs_regfile
    import i2cs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic              stb_o,
    output logic [BYTE_W-1:0] addr_o,
    output logic [BYTE_W-1:0] data_o,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int         AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [8:0] DEPTH_W = 9'(DEPTH);

    logic [BYTE_W-1:0] bank [DEPTH];
    logic              wr_in_range;
    logic              rd_in_range;

    assign wr_in_range = {1'b0, wr.addr} < DEPTH_W;
    assign rd_in_range = {1'b0, rd_addr} < DEPTH_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            stb_o  <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            stb_o <= wr.req && wr_in_range;
            if (wr.req && wr_in_range) begin
                bank[wr.addr[AW-1:0]] <= wr.data;
                addr_o <= wr.addr;
                data_o <= wr.data;
            end
        end
    end

    assign rd_data = rd_in_range ? bank[rd_addr[AW-1:0]] : '0;

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o); // R6

    AST_STB_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> ({1'b0, addr_o} < DEPTH_W)); // R8

endmodule

// File: rtl/i2c_regbank_slave.sv
`timescale 1ns/1ps
module i2c_regbank_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h42,
    parameter int         DEPTH       = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       wr_stb_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    input  logic [7:0] rd_addr_i,
    output logic [7:0] rd_data_o
);

    bus_ev_t ev;
    wr_req_t wr;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cs_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .sda_pull (sda_pull_o),
        .wr       (wr)
    );

    i2cs_regfile #(.DEPTH(DEPTH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (rd_addr_i),
        .stb_o   (wr_stb_o),
        .addr_o  (wr_addr_o),
        .data_o  (wr_data_o),
        .rd_data (rd_data_o)
    );

endmodule

// File: tb/test_i2c_regbank_slave.sv
`timescale 1ns/1ps
module test_i2c_regbank_slave;

    localparam int Q     = 40;
    localparam int DEPTH = 16;
    localparam logic [6:0] DEV = 7'h42;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_line;
    logic sda_pull_o, wr_stb_o;
    logic [7:0] wr_addr_o, wr_data_o, rd_addr_i, rd_data_o;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    logic [7:0] last_addr = 8'h00, last_data = 8'h00;
    logic [7:0] model [DEPTH];
    logic finished = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_drv & ~sda_pull_o;

    i2c_regbank_slave #(.DEV_ADDR(DEV), .DEPTH(DEPTH)) i_i2c_regbank_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    always @(posedge clk) begin
        if (!rst && wr_stb_o) begin
            stb_cnt   <= stb_cnt + 1;
            last_addr <= wr_addr_o;
            last_data <= wr_data_o;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        rd_addr_i = a;
        @(negedge clk);
        v = rd_data_o;
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; #(Q);
        scl = 1'b1;     #(Q);
        sda_drv = 1'b0; #(Q);
        scl = 1'b0;     #(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; #(Q);
        scl = 1'b1;     #(Q);
        sda_drv = 1'b1; #(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; #(Q);
            scl = 1'b1;     #(Q);
            scl = 1'b0;     #(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_drv = 1'b1; #(Q);
        scl = 1'b1;     #(Q/2);
        ack = (sda_line == 1'b0);
        #(Q/2);
        scl = 1'b0;     #(Q);
    endtask

    task automatic burst(input logic [7:0] ptr, input logic [7:0] d0,
                         input logic [7:0] d1, input int nd, output logic all_ack);
        logic a0, a1, a2, a3;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(ptr, a1);
        send_byte(d0, a2);
        a3 = 1'b1;
        if (nd > 1) send_byte(d1, a3);
        bus_stop();
        all_ack = a0 & a1 & a2 & a3;
    endtask

    localparam logic [23:0] VEC [4] = '{
        {8'h00, 8'hA5, 8'h5A},
        {8'h07, 8'h11, 8'h22},
        {8'h0E, 8'hC3, 8'h3C},
        {8'h03, 8'hFF, 8'h81}
    };

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic ok, a0, a1, a2;
        int s0;
        logic all_zero;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        rd_addr_i = 8'h00;
        repeat (6) @(negedge clk);
        check("R1 pull in reset", sda_pull_o, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 pull after reset", sda_pull_o, 0);
        check("R1 strobe after reset", wr_stb_o, 0);
        all_zero = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            peek(8'(i), v);
            if (v !== 8'h00) all_zero = 1'b0;
        end
        check("R1 bank zero", all_zero, 1);

        // R3 R5 R6: table of burst writes
        for (int k = 0; k < 4; k++) begin
            logic [7:0] p, d0, d1;
            {p, d0, d1} = VEC[k];
            s0 = stb_cnt;
            burst(p, d0, d1, 2, ok);
            model[p] = d0;
            model[p + 8'd1] = d1;
            check("R3 all bytes acked", ok, 1);
            check("R6 two strobes", stb_cnt - s0, 2);
            check("R6 last strobe addr", last_addr, p + 8'd1);
            peek(p, v);
            check("R6 first data", v, d0);
            peek(p + 8'd1, v);
            check("R6 next data (pointer step)", v, d1);
        end

        // R4: wrong device address
        s0 = stb_cnt;
        bus_start();
        send_byte({7'h43, 1'b0}, a0);
        send_byte(8'h0A, a1);
        send_byte(8'h55, a2);
        bus_stop();
        check("R4 wrong addr no ack", a0 | a1 | a2, 0);
        check("R4 wrong addr no write", stb_cnt - s0, 0);
        peek(8'h0A, v);
        check("R4 reg untouched", v, 8'h00);

        // R4: read direction
        s0 = stb_cnt;
        bus_start();
        send_byte({DEV, 1'b1}, a0);
        send_byte(8'h0B, a1);
        send_byte(8'h66, a2);
        bus_stop();
        check("R4 read dir no ack", a0 | a1 | a2, 0);
        check("R4 read dir no write", stb_cnt - s0, 0);

        // R5, R9, R10: repeated START
        s0 = stb_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h05, a1);
        check("R5 pointer byte no write", stb_cnt - s0, 0);
        sda_drv = 1'b1; #(Q/2);
        check("R10 released after ack", sda_pull_o, 0);
        #(Q/2);
        send_byte(8'h77, a2);
        model[5] = 8'h77;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        check("R9 addr acked after repeated start", a0, 1);
        send_byte(8'h09, a1);
        send_byte(8'h99, a2);
        model[9] = 8'h99;
        bus_stop();
        check("R9 writes on both sides", stb_cnt - s0, 2);
        peek(8'h09, v);
        check("R9 second reg", v, 8'h99);
        peek(8'h05, v);
        check("R9 first reg", v, 8'h77);

        // R8: beyond depth
        s0 = stb_cnt;
        burst(8'h20, 8'h6C, 8'h00, 1, ok);
        check("R8 out of range acked", ok, 1);
        check("R8 out of range no strobe", stb_cnt - s0, 0);

        // R7: pointer wrap 0xFF -> 0x00
        s0 = stb_cnt;
        burst(8'hFF, 8'hAB, 8'hCD, 2, ok);
        model[0] = 8'hCD;
        check("R7 wrap acked", ok, 1);
        check("R7 one strobe after wrap", stb_cnt - s0, 1);
        check("R7 wrapped addr", last_addr, 8'h00);
        peek(8'h00, v);
        check("R7 reg0 after wrap", v, 8'hCD);

        // R2: STOP mid byte aborts
        s0 = stb_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h02, a1);
        send_bits(8'hA0, 4);
        bus_stop();
        check("R2 aborted byte no strobe", stb_cnt - s0, 0);
        check("R2 idle pull released", sda_pull_o, 0);
        burst(8'h0C, 8'h3E, 8'h00, 1, ok);
        model[12] = 8'h3E;
        check("R2 next transfer after stop", ok, 1);

        // R6 R8: whole bank vs model
        all_zero = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            peek(8'(i), v);
            if (v !== model[i]) all_zero = 1'b0;
        end
        check("R8 bank matches model", all_zero, 1);
        check("R6 last data", last_data, 8'h3E);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule